// File: doc/BRIEF.md
# Masked Time Alarm Comparator

This block watches a running calendar time (day of month, hours, minutes and seconds, all in BCD) and compares it with four alarm registers programmed over a simple register bus. The compare is evaluated only on the cycle where the time source pulses its seconds-update strobe. When every field that takes part in the compare equals its alarm value, a sticky alarm flag is set. The flag can pull an active-low interrupt line low.

Each alarm register keeps a skip bit in its most significant bit. A field with its skip bit set always counts as matching. This turns one alarm into a repeating alarm: with every field skipped it fires every second, and with only the day skipped it fires once a day. An interrupt control register holds the enable that lets the flag reach the interrupt pin. It also holds a second enable that keeps the interrupt alive while the system runs from its backup supply. Software clears the flag by reading the status register, and that read also releases the interrupt line.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset all alarm registers and the interrupt control register read 0x00, the alarm flag is 0 and `irq_n` is 1.
- R2: Register offsets (4-bit address): 0x0 status (flag in bit 6, other bits read 0), 0x2 seconds alarm, 0x3 minutes alarm, 0x4 hours alarm, 0x5 day alarm, 0x6 interrupt control. Offsets 0x2 to 0x6 store and read back the full written byte. Every other offset reads 0x00, and `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R3: On a cycle with `tick` high, the flag is set at the next clock edge when every field whose skip bit is clear is equal to its alarm value. Seconds and minutes compare bits 6:0. Hours and day compare bits 5:0.
- R4: Bit 7 of an alarm register is its skip bit. A field with bit 7 set always matches, so with all four skip bits set, every `tick` sets the flag.
- R5: Without `tick` the flag is never set, even if the time equals the alarm values.
- R6: A read of offset 0x0 returns the flag as it was before the read, and the flag is 0 after that clock edge. If a setting match occurs in the same cycle as the read, the flag stays 1.
- R7: `irq_n` is 0 exactly when the flag is 1, interrupt control bit 7 is 1, and either `on_backup` is 0 or interrupt control bit 5 is 1. The pin responds in the same cycle to `on_backup`.
- R8: Writes to offset 0x0 and to unmapped offsets change no readable state. When read and write coincide, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse each time the seconds value updates |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| on_backup | input | 1 | System is running from its backup supply |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest cases to reach are full matches with no skip bits set. Random BCD times almost never agree in all four fields, so most draws copy the programmed alarm values into the time inputs and then perturb one field, or set an upper bit that the compare must ignore. Two collisions need exact cycle placement and get directed sequences: a status read in the same cycle as a setting tick, and a swing of `on_backup` while the flag is held. A cycle-accurate bench model checks `irq_n` on every cycle and checks `bus_rdata` on every read.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] OFS_STATUS   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ALM_BASE = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_INTCTL   = 4'h6;

    localparam int FLAG_BIT = 6;
    localparam int IEN_BIT  = 7;
    localparam int BKEN_BIT = 5;
    localparam int SKIP_BIT = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t [NUM_FIELDS-1:0] alm;
        byte_t                  intctl;
    } regs_t;

    // Bits of a field that take part in the compare: index 0 and 1 are
    // seconds and minutes (7 bits), index 2 and 3 are hours and day (6 bits).
    function automatic byte_t cmp_bits(input int idx);
        return (idx < 2) ? 8'h7F : 8'h3F;
    endfunction

    function automatic logic [ADDR_W-1:0] alm_ofs(input int idx);
        return OFS_ALM_BASE + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_wdata,
    output regs_t             regs_q
);

    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (bus_addr == alm_ofs(i)) begin
                    regs_d.alm[i] = bus_wdata;
                end
            end
            if (bus_addr == OFS_INTCTL) begin
                regs_d.intctl = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_cmp_pkg::*;
(
    input  byte_t [NUM_FIELDS-1:0] cur_time,
    input  byte_t [NUM_FIELDS-1:0] alm,
    output logic                   match
);

    logic [NUM_FIELDS-1:0] field_hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam byte_t CMP_MASK = cmp_bits(g);
        byte_t diff;
        always_comb begin
            diff         = (cur_time[g] ^ alm[g]) & CMP_MASK;
            field_hit[g] = alm[g][SKIP_BIT] || (diff == '0);
        end
    end

    assign match = &field_hit;

endmodule

// File: rtl/alarm_flag.sv
module alarm_flag
    import alarm_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic clr_req,
    input  logic irq_en,
    input  logic bk_en,
    input  logic on_backup,
    output logic flag,
    output logic irq_n
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick && match) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign irq_n = ~(st_q.flag & irq_en & (~on_backup | bk_en));

endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
    import alarm_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_date,
    input  logic       on_backup,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_n
);

    regs_t                  regs_q;
    byte_t [NUM_FIELDS-1:0] cur_time;
    logic                   match_w;
    logic                   flag_w;
    logic                   clr_w;

    assign cur_time = {cur_date, cur_hour, cur_min, cur_sec};
    assign clr_w    = bus_rd && (bus_addr == OFS_STATUS);

    alarm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .regs_q    (regs_q)
    );

    alarm_match u_match (
        .cur_time (cur_time),
        .alm      (regs_q.alm),
        .match    (match_w)
    );

    alarm_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .match     (match_w),
        .clr_req   (clr_w),
        .irq_en    (regs_q.intctl[IEN_BIT]),
        .bk_en     (regs_q.intctl[BKEN_BIT]),
        .on_backup (on_backup),
        .flag      (flag_w),
        .irq_n     (irq_n)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == OFS_STATUS) begin
                bus_rdata[FLAG_BIT] = flag_w;
            end else if (bus_addr == OFS_INTCTL) begin
                bus_rdata = regs_q.intctl;
            end else begin
                for (int i = 0; i < NUM_FIELDS; i++) begin
                    if (bus_addr == alm_ofs(i)) begin
                        bus_rdata = regs_q.alm[i];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk
    import alarm_cmp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       match,
    input logic       flag,
    input logic       irq_n,
    input logic       bus_rd,
    input logic [3:0] bus_addr,
    input logic       irq_en,
    input logic       bk_en,
    input logic       on_backup,
    input logic [3:0] skips
);

    assert_set_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> flag);

    assert_all_skipped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&skips)) |=> flag);

    assert_rise_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick && match));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_STATUS && !(tick && match)) |=> !flag);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag && irq_en));

    assert_backup_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (on_backup && !bk_en) |-> irq_n);

endmodule

bind alarm_cmp_top alarm_cmp_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .match     (match_w),
    .flag      (flag_w),
    .irq_n     (irq_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .irq_en    (regs_q.intctl[7]),
    .bk_en     (regs_q.intctl[5]),
    .on_backup (on_backup),
    .skips     ({regs_q.alm[3][7], regs_q.alm[2][7], regs_q.alm[1][7], regs_q.alm[0][7]})
);

// File: tb/alarm_cmp_top_tb_top.sv
module alarm_cmp_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic       on_backup = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_alm [4];
    logic [7:0] m_int;
    logic       m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_cmp_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .on_backup(on_backup), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_match(input logic [7:0] s, m, h, d);
        logic [7:0] cur [4];
        logic ok = 1'b1;
        cur[0] = s; cur[1] = m; cur[2] = h; cur[3] = d;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] bits = (i < 2) ? 8'h7F : 8'h3F;
            if (!m_alm[i][7] && (((cur[i] ^ m_alm[i]) & bits) != 8'h00)) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        if (a == 4'h0) return {1'b0, m_flag, 6'b0};
        if (a >= 4'h2 && a <= 4'h5) return m_alm[a - 4'h2];
        if (a == 4'h6) return m_int;
        return 8'h00;
    endfunction

    function automatic logic exp_irq(input logic bk);
        return !(m_flag && m_int[7] && (!bk || m_int[5]));
    endfunction

    // One clock cycle: drive at the falling edge, check, update model at the rising edge.
    task automatic cyc(input logic t, input logic [7:0] s, m, h, d, input logic bk,
                       input logic wr, input logic rd, input logic [3:0] a,
                       input logic [7:0] wd, input string tag);
        logic nxt_flag;
        tick = t; cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
        on_backup = bk; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #1;
        if (rd) check(bus_rdata, exp_rd(a), tag);
        else    check(bus_rdata, 8'h00, "R2 idle bus");
        check({7'd0, irq_n}, {7'd0, exp_irq(bk)}, "R7 irq pin");
        nxt_flag = m_flag;
        if (t && exp_match(s, m, h, d)) nxt_flag = 1'b1;
        else if (rd && a == 4'h0)       nxt_flag = 1'b0;
        @(posedge clk);
        m_flag = nxt_flag;
        if (wr) begin
            if (a >= 4'h2 && a <= 4'h5) m_alm[a - 4'h2] = wd;
            if (a == 4'h6) m_int = wd;
        end
        @(negedge clk);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] v);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, a, v, "R2 write");
    endtask

    task automatic rreg(input logic [3:0] a, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, a, 0, tag);
    endtask

    task automatic tk(input logic [7:0] s, m, h, d);
        cyc(1, s, m, h, d, 0, 0, 0, 0, 0, "R3 tick");
    endtask

    function automatic logic [7:0] rand_bcd(input int max);
        int v = $urandom_range(max);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_0A1A);
        for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
        m_int = 8'h00; m_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) rreg(4'(a), "R1 reset value");
        check({7'd0, irq_n}, 8'h01, "R1 irq idle");

        // R2: readback and unmapped; R8: write to status/unmapped ignored
        wreg(4'h2, 8'h45); wreg(4'h3, 8'h30); wreg(4'h4, 8'h12); wreg(4'h5, 8'h28);
        wreg(4'h6, 8'h80);
        wreg(4'h0, 8'hFF); wreg(4'h1, 8'hAA); wreg(4'hF, 8'h55);
        for (int a = 0; a < 16; a++) rreg(4'(a), "R2 readback R8 ignored");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 4'h2, 8'h46, "R8 read before write");
        rreg(4'h2, "R2 new value");

        // R3: full match sets flag, off-by-one does not; R5: no tick no set
        tk(8'h46, 8'h30, 8'h13, 8'h28);
        rreg(4'h0, "R3 near miss hours");
        cyc(0, 8'h46, 8'h30, 8'h12, 8'h28, 0, 0, 0, 0, 0, "R5 match without tick");
        rreg(4'h0, "R5 flag stays clear");
        tk(8'h46, 8'h30, 8'h52, 8'h28);
        rreg(4'h0, "R3 hours bit6 ignored");
        tk(8'h46, 8'h30, 8'h12, 8'h28);
        check({7'd0, irq_n}, 8'h00, "R7 irq asserted");
        rreg(4'h0, "R6 read shows flag");
        rreg(4'h0, "R6 flag cleared");

        // R7: backup gating with enable bits
        tk(8'h46, 8'h30, 8'h12, 8'h28);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 backup blocks");
        wreg(4'h6, 8'hA0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 backup enabled");
        wreg(4'h6, 8'h20);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 no main enable");

        // R6: set and clear in the same cycle; set wins
        wreg(4'h6, 8'h80);
        cyc(1, 8'h46, 8'h30, 8'h12, 8'h28, 0, 0, 1, 4'h0, 0, "R6 read on setting tick");
        rreg(4'h0, "R6 set wins");

        // R4: all skipped gives every tick
        for (int i = 2; i < 6; i++) wreg(4'(i), 8'h80);
        for (int k = 0; k < 4; k++) begin
            tk(rand_bcd(59), rand_bcd(59), rand_bcd(23), rand_bcd(31));
            rreg(4'h0, "R4 every second");
        end
        // R4: only seconds compared
        wreg(4'h2, 8'h07);
        tk(8'h08, 8'h11, 8'h22, 8'h03); rreg(4'h0, "R4 seconds differ");
        tk(8'h07, 8'h59, 8'h23, 8'h31); rreg(4'h0, "R4 seconds only");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom_range(9);
            logic bk = ($urandom_range(3) == 0);
            if (op < 2) begin
                logic [7:0] v;
                int f = $urandom_range(3);
                v = (f < 2) ? rand_bcd(59) : (f == 2 ? rand_bcd(23) : rand_bcd(31));
                if ($urandom_range(2) == 0) v[7] = 1'b1;
                cyc(0, 0, 0, 0, 0, bk, 1, $urandom_range(1) == 1, 4'(f + 2), v, "R2 random write");
            end else if (op == 2) begin
                cyc(0, 0, 0, 0, 0, bk, 1, 0, 4'h6, 8'($urandom), "R7 random intctl");
            end else if (op < 5) begin
                cyc(0, 0, 0, 0, 0, bk, 0, 1, 4'($urandom), 0, "R6 random read");
            end else begin
                logic [7:0] t [4];
                for (int i = 0; i < 4; i++) t[i] = m_alm[i] & ((i < 2) ? 8'h7F : 8'h3F);
                if ($urandom_range(2) == 0) t[$urandom_range(3)] = rand_bcd(23);
                if ($urandom_range(3) == 0) t[2][6] = 1'b1;
                cyc($urandom_range(4) != 0, t[0], t[1], t[2], t[3], bk, 0,
                    $urandom_range(5) == 0, 4'h0, 0, "R3 random tick");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule